// File: doc/BRIEF.md
# Gated-Count Phase Detector

This block produces the error samples that drive the loop filter of a digital phase-locked loop. A slow reference clock is divided by a programmable ratio N. Every N reference cycles the divided reference closes one measurement window and opens the next. Inside each window the block counts rising edges of the feedback clock, which comes from the controlled oscillator. The counter runs on the feedback clock, so every window is measured in oscillator periods.

When a window closes, its count is compared with a programmable expected count. The difference leaves the block as a signed error sample, together with a one-cycle strobe in the feedback domain. The ratio N sets how often samples are produced. The expected count sets the operating point: an error of zero means the oscillator ran at exactly the target multiple of the reference for that window.

The window boundary is carried from the reference domain by a toggle. A short synchronizer and an edge detector pick it up in the feedback domain. At each boundary the running count is captured and the counter restarts, counting the boundary cycle itself, so that consecutive windows tile the feedback clock without gaps or overlaps. The window that is open when reset is released has no defined start, and its result is dropped.

Top module: `gated_count_phase_det`

## Requirements
- R1: The reference is divided by `div_n`: one window boundary is produced every `div_n` reference cycles, and a value of 0 on `div_n` behaves exactly like 1.
- R2: When the reference period is an exact multiple M of the feedback period, every reported window holds exactly M×`div_n` feedback cycles.
- R3: Consecutive windows tile the feedback clock with no cycle lost or counted twice. With a non-integer ratio r of feedback cycles per window, each count is floor(r) or ceil(r), and the sum over K consecutive windows is within 1 of K×r.
- R4: `err_out` is the window count minus `nominal`, as a 24-bit two's complement value. It is negative when `nominal` exceeds the count, and this also holds for `nominal` at its maximum of 2^23−1.
- R5: `err_valid` is high for exactly one feedback cycle per sample. Between strobes, `err_out` holds its last value.
- R6: The window that is open when reset is released is discarded. The first strobe after reset carries the count of a complete window.
- R7: While reset is asserted, and after reset until the first sample, `err_out` is 0 and `err_valid` is 0.
- R8: With the reference period an exact multiple of the feedback period, strobes are exactly M×`div_n` feedback cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Reference clock to be divided |
| ref_rst | input | 1 | Synchronous active-high reset, reference domain |
| fb_clk | input | 1 | Feedback clock from the controlled oscillator |
| fb_rst | input | 1 | Synchronous active-high reset, feedback domain |
| div_n | input | 16 | Reference divide ratio N (0 treated as 1) |
| nominal | input | 23 | Expected feedback cycles per window |
| err_out | output | 24 | Signed error: window count minus nominal |
| err_valid | output | 1 | One-cycle strobe marking a new error sample |

## Verification
Any wrong state in the prescaler, the synchronizer or the window counter shows up at the ports within one or two windows. A counter that misses or repeats the boundary cycle shifts every exact-ratio count by one. It also breaks the running sum over fractional-ratio windows by at least one per window. A prescaler that mishandles the terminal count changes both the sample spacing and the count from the very next window on. A start-of-life flag that is wrong shows on the first strobe after reset, as a partial count or as a strobe that comes early.

// File: rtl/gcpd_pkg.sv
package gcpd_pkg;

    // Default widths of the divide ratio and the window counter.
    localparam int GCPD_DIV_W   = 16;
    localparam int GCPD_CNT_W   = 23;
    localparam int GCPD_SYNC_ST = 2;

    // The window tracker is either waiting for its first trusted boundary
    // or is producing samples.
    typedef enum logic [0:0] {
        WIN_SEEK = 1'b0,
        WIN_LIVE = 1'b1
    } win_state_e;

    // Divide ratio with zero mapped to one, returned as a terminal count.
    function automatic logic [GCPD_DIV_W-1:0] term_count(input logic [GCPD_DIV_W-1:0] n);
        return (n == '0) ? '0 : n - 1'b1;
    endfunction

endpackage

// File: rtl/gcpd_prescale.sv
module gcpd_prescale
    import gcpd_pkg::*;
#(
    parameter int DIV_W = GCPD_DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div_n,
    output logic             tgl
);
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] last;
    logic             tgl_q;

    always_comb begin
        last = (div_n == '0) ? '0 : div_n - 1'b1;
    end

    // A toggle rather than a pulse, so a slow destination never misses it.
    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            tgl_q <= 1'b0;
        end else if (cnt_q >= last) begin
            cnt_q <= '0;
            tgl_q <= ~tgl_q;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tgl = tgl_q;

    // R1: the toggle only moves when the divider has just wrapped.
    a_r1_toggle_on_wrap: assert property (@(posedge clk) disable iff (rst)
        (tgl_q != $past(tgl_q)) |-> (cnt_q == '0));

endmodule

// File: rtl/gcpd_sync.sv
module gcpd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic pulse
);
    logic [STAGES-1:0] sh_q;
    logic              hold_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) begin
                    sh_q[i] <= 1'b0;
                end else if (i == 0) begin
                    sh_q[i] <= d;
                end else begin
                    sh_q[i] <= sh_q[(i == 0) ? 0 : i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) hold_q <= 1'b0;
        else     hold_q <= sh_q[STAGES-1];
    end

    assign pulse = sh_q[STAGES-1] ^ hold_q;

    // R5: a boundary never occupies two consecutive feedback cycles.
    a_r5_pulse_isolated: assert property (@(posedge clk) disable iff (rst)
        pulse |=> !pulse);

endmodule

// File: rtl/gcpd_window.sv
module gcpd_window
    import gcpd_pkg::*;
#(
    parameter int CNT_W = GCPD_CNT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               boundary,
    input  logic [CNT_W-1:0]   nominal,
    output logic [CNT_W:0]     err_o,
    output logic               valid_o
);
    localparam int ERR_W = CNT_W + 1;

    logic [CNT_W-1:0]        cnt_q;
    logic [CNT_W-1:0]        cnt_nx;
    logic signed [ERR_W-1:0] diff;
    logic [ERR_W-1:0]        err_q;
    logic                    valid_q;
    win_state_e              state_q;

    // Saturate instead of wrapping on a pathologically long window.
    always_comb begin
        cnt_nx = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;
        diff   = $signed({1'b0, cnt_q}) - $signed({1'b0, nominal});
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            err_q   <= '0;
            valid_q <= 1'b0;
            state_q <= WIN_SEEK;
        end else begin
            valid_q <= 1'b0;
            if (boundary) begin
                // The boundary cycle opens the next window and counts in it.
                cnt_q   <= {{(CNT_W-1){1'b0}}, 1'b1};
                state_q <= WIN_LIVE;
                if (state_q == WIN_LIVE) begin
                    err_q   <= diff;
                    valid_q <= 1'b1;
                end
            end else begin
                cnt_q <= cnt_nx;
            end
        end
    end

    assign err_o   = err_q;
    assign valid_o = valid_q;

    // R5: the strobe lasts one cycle.
    a_r5_single_strobe: assert property (@(posedge clk) disable iff (rst)
        valid_q |=> !valid_q);
    // R5: the sample holds while no strobe is present.
    a_r5_hold_between: assert property (@(posedge clk) disable iff (rst)
        !valid_q |-> $stable(err_q));
    // R6: no sample leaves while the first window is still untrusted.
    a_r6_seek_silent: assert property (@(posedge clk) disable iff (rst)
        (state_q == WIN_SEEK) |=> !valid_q);
    // R3: once live, the counter always holds at least the boundary cycle.
    a_r3_count_nonzero: assert property (@(posedge clk) disable iff (rst)
        (state_q == WIN_LIVE) |-> (cnt_q != '0));

endmodule

// File: rtl/gated_count_phase_det.sv
module gated_count_phase_det
    import gcpd_pkg::*;
#(
    parameter int DIV_W       = GCPD_DIV_W,
    parameter int CNT_W       = GCPD_CNT_W,
    parameter int SYNC_STAGES = GCPD_SYNC_ST
) (
    input  logic             ref_clk,
    input  logic             ref_rst,
    input  logic             fb_clk,
    input  logic             fb_rst,
    input  logic [DIV_W-1:0] div_n,
    input  logic [CNT_W-1:0] nominal,
    output logic [CNT_W:0]   err_out,
    output logic             err_valid
);
    logic ref_tgl;
    logic boundary;

    gcpd_prescale #(.DIV_W(DIV_W)) u_prescale (
        .clk   (ref_clk),
        .rst   (ref_rst),
        .div_n (div_n),
        .tgl   (ref_tgl)
    );

    gcpd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (fb_clk),
        .rst   (fb_rst),
        .d     (ref_tgl),
        .pulse (boundary)
    );

    gcpd_window #(.CNT_W(CNT_W)) u_window (
        .clk      (fb_clk),
        .rst      (fb_rst),
        .boundary (boundary),
        .nominal  (nominal),
        .err_o    (err_out),
        .valid_o  (err_valid)
    );

    // R7: outputs are quiet right after reset.
    a_r7_reset_quiet: assert property (@(posedge fb_clk)
        $past(fb_rst) |-> (!err_valid && (err_out == '0)));

endmodule

// File: tb/gated_count_phase_det_test.sv
`timescale 1ns/1ps
module gated_count_phase_det_test;

    logic        ref_clk = 1'b0;
    logic        fb_clk  = 1'b0;
    logic        ref_rst = 1'b1;
    logic        fb_rst  = 1'b1;
    logic [15:0] div_n   = 16'd4;
    logic [22:0] nominal = '0;
    logic [23:0] err_out;
    logic        err_valid;

    int  tests = 0;
    int  fails = 0;
    int  ref_half = 6;
    bit  mon_en = 1'b0;
    int  cyc = 0;
    int  strobe_viol = 0;
    int  hold_viol = 0;
    bit  prev_valid = 1'b0;
    int  last_err = 0;
    int  samp_q[$];
    int  when_q[$];

    gated_count_phase_det uut (
        .ref_clk   (ref_clk),
        .ref_rst   (ref_rst),
        .fb_clk    (fb_clk),
        .fb_rst    (fb_rst),
        .div_n     (div_n),
        .nominal   (nominal),
        .err_out   (err_out),
        .err_valid (err_valid)
    );

    // 250 MHz feedback clock, rising edges on integer nanoseconds.
    initial forever #2 fb_clk = ~fb_clk;
    // Reference edges fall on half nanoseconds, never on a feedback edge.
    initial begin
        #0.5;
        forever #(ref_half) ref_clk = ~ref_clk;
    end

    always @(negedge fb_clk) begin
        cyc <= cyc + 1;
        if (mon_en) begin
            if (err_valid) begin
                samp_q.push_back(int'($signed(err_out)));
                when_q.push_back(cyc);
                if (prev_valid) strobe_viol <= strobe_viol + 1;
                last_err <= int'($signed(err_out));
            end else if (int'($signed(err_out)) != last_err) begin
                hold_viol <= hold_viol + 1;
            end
            prev_valid <= err_valid;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic get_sample(output int v, output int t);
        while (samp_q.size() == 0) @(negedge fb_clk);
        v = samp_q.pop_front();
        t = when_q.pop_front();
    endtask

    task automatic drop(input int k);
        int v, t;
        for (int i = 0; i < k; i++) get_sample(v, t);
    endtask

    function automatic int expect_err(input int n, input int mult, input int nom);
        int eff;
        eff = (n == 0) ? 1 : n;
        return eff * mult - nom;
    endfunction

    task automatic set_and_check(input int n, input int nom, input string tag);
        int v, t;
        @(negedge fb_clk);
        div_n   = 16'(n);
        nominal = 23'(nom);
        drop(2);
        get_sample(v, t);
        chk(v == expect_err(n, 3, nom), tag, v, expect_err(n, 3, nom));
    endtask

    initial begin
        #600000;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int v, t, v2, t2, sum, lo, hi;
        void'($urandom(32'd20240611));
        repeat (10) @(negedge fb_clk);
        // R7: quiet during reset
        chk(err_valid == 1'b0, "R7 valid in reset", int'(err_valid), 0);
        chk(err_out == '0, "R7 err in reset", int'(err_out), 0);
        fb_rst = 1'b0;
        mon_en = 1'b1;
        repeat (7) @(negedge fb_clk);
        ref_rst = 1'b0;
        repeat (5) @(negedge fb_clk);
        chk(err_valid == 1'b0 && samp_q.size() == 0, "R7 quiet after reset", samp_q.size(), 0);
        chk(err_out == '0, "R7 err after reset", int'(err_out), 0);

        // R6: first strobe is a full window of 3*4 cycles
        get_sample(v, t);
        chk(v == 12, "R6 first sample full window", v, 12);
        // R8: strobe spacing equals 3*N
        get_sample(v2, t2);
        chk(t2 - t == 12, "R8 strobe spacing", t2 - t, 12);
        chk(v2 == 12, "R2 exact count N=4", v2, 12);

        // R4: zero and negative errors
        set_and_check(4, 12, "R4 zero error");
        set_and_check(4, 20, "R4 negative error");
        set_and_check(4, 8388607, "R4 max nominal");
        // R1: N=1 and N=0 both divide by one
        set_and_check(1, 0, "R1 N=1");
        set_and_check(0, 0, "R1 N=0 as one");
        set_and_check(200, 100, "R2 long window");
        get_sample(v, t);
        get_sample(v2, t2);
        chk(t2 - t == 600, "R8 spacing N=200", t2 - t, 600);

        // R2/R4: random ratios and operating points
        for (int i = 0; i < 40; i++) begin
            int n, nom;
            n   = 1 + int'($urandom % 30);
            nom = int'($urandom % 200);
            set_and_check(n, nom, "R2 R4 random");
            get_sample(v, t);
            chk(v == expect_err(n, 3, nom), "R2 R4 random repeat", v, expect_err(n, 3, nom));
        end

        // R3: 2.5 feedback cycles per reference cycle, N=7 -> 17.5 per window
        @(negedge fb_clk);
        div_n   = 16'd7;
        nominal = '0;
        ref_half = 5;
        drop(3);
        sum = 0;
        for (int i = 0; i < 10; i++) begin
            get_sample(v, t);
            sum += v;
            chk(v == 17 || v == 18, "R3 fractional window", v, 17);
        end
        lo = 174;
        hi = 176;
        chk(sum >= lo && sum <= hi, "R3 running sum", sum, 175);

        // R5: strobe width and hold behaviour over the whole run
        chk(strobe_viol == 0, "R5 single-cycle strobe", strobe_viol, 0);
        chk(hold_viol == 0, "R5 hold between strobes", hold_viol, 0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule